// File: doc/BRIEF.md
# Shared-bus quad-SPI memory controller

This block connects a processor's instruction-fetch port and its data port to one quad-SPI bus. One flash device and two PSRAM devices share that bus. They share the clock and the four data lines, and each device has its own active-low chip select. A decoder on the data-port address picks the device. Instruction fetches always go to flash. Each request moves one 32-bit word and completes with a one-cycle ready pulse.

The flash is taken to be already in continuous-read mode, so a flash read has no command phase. The PSRAMs are taken to be in quad command mode, so each PSRAM access starts with a one-byte command. The read latency (0 to 3 SPI cycles) and a half-cycle early-sample option are taken from the data pads while reset is held low. Device set-up commands and error responses are not part of the block.

Top module: `qspi_shared_ctrl`

## Requirements
- R1: Data address bit 24 = 0 selects flash (`cs_flash_no`) and sends address bits 23:0. Bit 24 = 1 with bit 23 = 0 selects RAM A (`cs_rama_no`). Bit 24 = 1 with bit 23 = 1 selects RAM B (`cs_ramb_no`). For either RAM the device address sent is {0, addr[22:0]}.
- R2: At most one chip select is low at any time. While any reset is active, or while no chip select is low, all chip selects are high, `sd_oe_o` is 0 and `sck_o` is 0.
- R3: While `rst_ni` is low, each clock edge captures `sd_i[1:0]` as the read latency L (0..3) and `sd_i[2]` as the early-sample option H. Both hold after reset is released.
- R4: One SPI cycle is two clocks: SCK low, then SCK high. Outgoing nibbles change only when SCK falls.
- R5: A flash read sends 6 address nibbles, most significant nibble first. It then runs L dummy SPI cycles with the output enables off, then receives 8 data nibbles.
- R6: Data nibbles carry byte 0 first, and within each byte the high nibble comes first.
- R7: A flash read holds its chip select low for 2*(14+L)-H clocks.
- R8: With H=1, read nibbles are sampled at the end of the SCK-low phase rather than the SCK-high phase, and the final SCK-high phase is dropped.
- R9: A PSRAM read sends command 0xEB (high nibble first) before the address. It uses the same latency and sampling rules as a flash read, and holds its chip select low for 2*(16+L)-H clocks.
- R10: A PSRAM write sends command 0x38, then 6 address nibbles, then 8 data nibbles, with no dummy cycles. It holds its chip select low for 32 clocks whatever L and H are.
- R11: A data-port write to a flash address is dropped. No chip select falls, the flash contents are unchanged, and `data_ready_o` still pulses.
- R12: When both ports request in the same cycle, the data port is served first. The fetch waits until that chip select has risen.
- R13: `*_ready_o` is a one-cycle pulse on the port that was served, in the cycle after its chip select rises, and the read word is valid in that cycle. The two ready outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; latency options are sampled while low |
| instr_req_i | input | 1 | Fetch request, held until ready |
| instr_addr_i | input | 24 | Fetch byte address (flash) |
| instr_ready_o | output | 1 | Fetch complete pulse |
| instr_rdata_o | output | 32 | Fetched word |
| data_req_i | input | 1 | Data request, held until ready |
| data_we_i | input | 1 | Data write when high |
| data_addr_i | input | 25 | Data byte address |
| data_wdata_i | input | 32 | Write word |
| data_ready_o | output | 1 | Data complete pulse |
| data_rdata_o | output | 32 | Read word |
| sck_o | output | 1 | Bus clock |
| sd_i | input | 4 | Data pads in |
| sd_o | output | 4 | Data pads out |
| sd_oe_o | output | 4 | Data pad output enables |
| cs_flash_no | output | 1 | Flash chip select, active low |
| cs_rama_no | output | 1 | RAM A chip select, active low |
| cs_ramb_no | output | 1 | RAM B chip select, active low |

## Verification
The bench models all three devices on the shared pads and measures how long each chip select stays low. This catches a controller that inserts dummy cycles on writes, ignores the early-sample option, or counts the latency wrongly. Reloading several latency and sample settings through reset checks that the captured values really govern the frame; a controller with a fixed latency would return shifted words and the wrong frame lengths. Writes to one RAM followed by reads of the other catch a decoder that confuses the bank bit, and a flash write that raised a chip select would show up as an extra select. Simultaneous requests verify the order of service, since an inverted arbiter would select flash first.

// File: rtl/qspi_ctrl_pkg.sv
package qspi_ctrl_pkg;
  typedef enum logic [1:0] {DEV_FLASH = 2'd0, DEV_RAM_A = 2'd1, DEV_RAM_B = 2'd2} dev_e;
  localparam logic [7:0] CMD_RD   = 8'hEB;
  localparam logic [7:0] CMD_WR   = 8'h38;
  localparam int         NIB_CMD  = 2;
  localparam int         NIB_WORD = 8;
endpackage

// File: rtl/qspi_addr_dec.sv
module qspi_addr_dec
  import qspi_ctrl_pkg::*;
#(
  parameter int DEV_AW = 24
) (
  input  logic [DEV_AW:0]   addr_i,
  output dev_e              dev_o,
  output logic [DEV_AW-1:0] dev_addr_o
);
  always_comb begin
    if (!addr_i[DEV_AW]) begin
      dev_o      = DEV_FLASH;
      dev_addr_o = addr_i[DEV_AW-1:0];
    end else begin
      dev_o      = addr_i[DEV_AW-1] ? DEV_RAM_B : DEV_RAM_A;
      dev_addr_o = {1'b0, addr_i[DEV_AW-2:0]};
    end
  end
endmodule

// File: rtl/qspi_bus_seq.sv
module qspi_bus_seq
  import qspi_ctrl_pkg::*;
#(
  parameter int DEV_AW = 24,
  parameter int LAT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  dev_e              dev_i,
  input  logic              we_i,
  input  logic [DEV_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              half_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              sck_o,
  input  logic [3:0]        sd_i,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o,
  output logic [2:0]        cs_no
);
  localparam int NIB_ADDR = DEV_AW / 4;
  localparam int IDX_W    = $clog2(NIB_CMD + NIB_ADDR + (1 << LAT_W) + NIB_WORD);
  localparam logic [2:0] LAST_A = 3'(NIB_ADDR - 1);

  logic              run_q, ph_q, done_q, we_q, ram_q;
  logic [IDX_W-1:0]  idx_q, pre_q, last_q;
  logic [DEV_AW-1:0] addr_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [2:0]        cs_n_q;

  logic [IDX_W-1:0]  cmd_len, pre_n;
  logic [2:0]        a_nib, d_nib;
  logic [4:0]        a_sh, d_sh;
  logic              in_cmd, in_addr, in_data, sample, fin, oe;
  logic [7:0]        cmd;
  logic [3:0]        nib;

  assign cmd_len = ram_q ? IDX_W'(NIB_CMD) : '0;
  assign in_cmd  = idx_q < cmd_len;
  assign in_addr = idx_q < cmd_len + IDX_W'(NIB_ADDR);
  assign in_data = idx_q >= pre_q;
  assign a_nib   = idx_q[2:0] - cmd_len[2:0];
  assign d_nib   = idx_q[2:0] - pre_q[2:0];
  assign a_sh    = {LAST_A - a_nib, 2'b00};
  // byte 0 first, high nibble first inside a byte
  assign d_sh    = {d_nib[2:1], ~d_nib[0], 2'b00};
  assign cmd     = we_q ? CMD_WR : CMD_RD;

  always_comb begin
    nib = '0;
    oe  = 1'b0;
    if (run_q) begin
      if (in_cmd) begin
        nib = idx_q[0] ? cmd[3:0] : cmd[7:4];
        oe  = 1'b1;
      end else if (in_addr) begin
        nib = addr_q[a_sh +: 4];
        oe  = 1'b1;
      end else if (in_data && we_q) begin
        nib = wdata_q[d_sh +: 4];
        oe  = 1'b1;
      end
    end
  end

  assign sample = run_q && !we_q && in_data && (half_i ? !ph_q : ph_q);
  assign fin    = run_q && (idx_q == last_q) && (ph_q || (half_i && !we_q));
  assign pre_n  = ((dev_i != DEV_FLASH) ? IDX_W'(NIB_CMD) : '0) + IDX_W'(NIB_ADDR)
                + (we_i ? '0 : IDX_W'(lat_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; ph_q <= 1'b0; done_q <= 1'b0; we_q <= 1'b0; ram_q <= 1'b0;
      idx_q <= '0; pre_q <= '0; last_q <= '0;
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
      cs_n_q <= '1;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q   <= 1'b1;
        ph_q    <= 1'b0;
        idx_q   <= '0;
        we_q    <= we_i;
        ram_q   <= dev_i != DEV_FLASH;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        pre_q   <= pre_n;
        last_q  <= pre_n + IDX_W'(NIB_WORD - 1);
        cs_n_q  <= ~(3'b001 << dev_i);
      end else if (run_q) begin
        if (sample) rdata_q[d_sh +: 4] <= sd_i;
        if (fin) begin
          run_q  <= 1'b0;
          ph_q   <= 1'b0;
          cs_n_q <= '1;
          done_q <= 1'b1;
        end else if (ph_q) begin
          ph_q  <= 1'b0;
          idx_q <= idx_q + 1'b1;
        end else begin
          ph_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = run_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign sck_o   = ph_q;
  assign sd_o    = nib;
  assign sd_oe_o = {4{oe}};
  assign cs_no   = cs_n_q;

  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_q) <= 1); // R2
  AST_SCK_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_q) |-> !(&cs_n_q)); // R4
  AST_DONE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (&cs_n_q)); // R13
  AST_NO_FLASH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !run_q && we_i) |-> dev_i != DEV_FLASH); // R11
endmodule

// File: rtl/qspi_shared_ctrl.sv
module qspi_shared_ctrl
  import qspi_ctrl_pkg::*;
#(
  parameter int DEV_AW = 24,
  parameter int LAT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_req_i,
  input  logic [DEV_AW-1:0] instr_addr_i,
  output logic              instr_ready_o,
  output logic [31:0]       instr_rdata_o,
  input  logic              data_req_i,
  input  logic              data_we_i,
  input  logic [DEV_AW:0]   data_addr_i,
  input  logic [31:0]       data_wdata_i,
  output logic              data_ready_o,
  output logic [31:0]       data_rdata_o,
  output logic              sck_o,
  input  logic [3:0]        sd_i,
  output logic [3:0]        sd_o,
  output logic [3:0]        sd_oe_o,
  output logic              cs_flash_no,
  output logic              cs_rama_no,
  output logic              cs_ramb_no
);
  logic [LAT_W-1:0]  lat_q;
  logic              half_q;
  dev_e              d_dev, s_dev;
  logic [DEV_AW-1:0] d_addr, s_addr;
  logic              busy, done, owner_q, skip_q, idle, go, skip, start, s_we;
  logic [31:0]       rdata;
  logic [2:0]        cs_n;

  // latency options sampled from the pads while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lat_q  <= sd_i[LAT_W-1:0];
      half_q <= sd_i[2];
    end
  end

  qspi_addr_dec #(.DEV_AW(DEV_AW)) u_dec (
    .addr_i(data_addr_i), .dev_o(d_dev), .dev_addr_o(d_addr)
  );

  assign idle   = !busy && !done && !skip_q;
  assign go     = idle && (data_req_i || instr_req_i);
  assign skip   = go && data_req_i && data_we_i && d_dev == DEV_FLASH;
  assign start  = go && !skip;
  assign s_dev  = data_req_i ? d_dev : DEV_FLASH;
  assign s_addr = data_req_i ? d_addr : instr_addr_i;
  assign s_we   = data_req_i && data_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      skip_q <= skip;
      if (go) owner_q <= data_req_i;
    end
  end

  qspi_bus_seq #(.DEV_AW(DEV_AW), .LAT_W(LAT_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .dev_i(s_dev), .we_i(s_we), .addr_i(s_addr),
    .wdata_i(data_wdata_i), .lat_i(lat_q), .half_i(half_q),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .sck_o, .sd_i, .sd_o, .sd_oe_o, .cs_no(cs_n)
  );

  assign cs_flash_no   = cs_n[DEV_FLASH];
  assign cs_rama_no    = cs_n[DEV_RAM_A];
  assign cs_ramb_no    = cs_n[DEV_RAM_B];
  assign data_ready_o  = (done && owner_q) || skip_q;
  assign instr_ready_o = done && !owner_q;
  assign data_rdata_o  = rdata;
  assign instr_rdata_o = rdata;

  AST_READY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(instr_ready_o && data_ready_o)); // R13
  AST_OE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_flash_no && cs_rama_no && cs_ramb_no) |-> sd_oe_o == 4'h0); // R2
  AST_SKIP_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> (cs_flash_no && cs_rama_no && cs_ramb_no)); // R11
endmodule

// File: tb/tb_qspi_shared_ctrl.sv
`timescale 1ns/1ps
module tb_qspi_shared_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic instr_req = 0, data_req = 0, data_we = 0;
  logic [23:0] instr_addr = '0;
  logic [24:0] data_addr = '0;
  logic [31:0] data_wdata = '0;
  logic instr_ready_o, data_ready_o, sck_o, cs_flash_no, cs_rama_no, cs_ramb_no;
  logic [31:0] instr_rdata_o, data_rdata_o;
  logic [3:0] sd_i, sd_o, sd_oe_o, cfg_nib = '0, dev_nib = '0;
  logic dev_oe = 1'b0;

  always #2.5 clk = ~clk;

  qspi_shared_ctrl dut (
    .clk_i(clk), .rst_ni,
    .instr_req_i(instr_req), .instr_addr_i(instr_addr), .instr_ready_o, .instr_rdata_o,
    .data_req_i(data_req), .data_we_i(data_we), .data_addr_i(data_addr),
    .data_wdata_i(data_wdata), .data_ready_o, .data_rdata_o,
    .sck_o, .sd_i, .sd_o, .sd_oe_o, .cs_flash_no, .cs_rama_no, .cs_ramb_no
  );

  assign sd_i = dev_oe ? dev_nib : cfg_nib;

  int checks = 0, fails = 0;
  int lat_cfg = 0, cur_len = 0, last_len = 0;
  int falls [3];
  logic [31:0] mem [3][16];
  logic [2:0] csv;
  assign csv = {cs_ramb_no, cs_rama_no, cs_flash_no};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int npos(int d);
    return 8 * (d / 2) + (((d % 2) == 0) ? 4 : 0);
  endfunction

  // device model on the shared pads
  int dsel = -1, rise = 0, dev_pre = 0;
  bit dev_wr = 0;
  logic [31:0] hdr = '0, wacc = '0, last_hdr = '0;

  always @(csv) begin
    if (csv == 3'b111) begin
      if (dsel > 0 && dev_wr && rise >= dev_pre + 8) mem[dsel][hdr[5:2]] = wacc;
      if (dsel >= 0) last_hdr = hdr;
      dsel = -1;
      dev_oe = 1'b0;
    end else if (dsel < 0) begin
      dsel = (csv == 3'b110) ? 0 : (csv == 3'b101) ? 1 : 2;
      rise = 0; hdr = '0; wacc = '0; dev_wr = 0;
      dev_pre = (dsel == 0) ? 6 + lat_cfg : 8 + lat_cfg;
      falls[dsel]++;
    end
  end

  always @(posedge sck_o) if (dsel >= 0) begin
    if (rise < ((dsel == 0) ? 6 : 8)) hdr = {hdr[27:0], sd_o};
    if (dsel > 0 && rise == 1) begin
      dev_wr  = (hdr[7:0] == 8'h38);
      dev_pre = dev_wr ? 8 : 8 + lat_cfg;
    end
    if (dev_wr && rise >= dev_pre) wacc[npos(rise - dev_pre) +: 4] = sd_o;
    rise++;
  end

  always @(negedge sck_o) if (dsel >= 0 && !dev_wr && rise >= dev_pre && rise < dev_pre + 8) begin
    dev_nib = mem[dsel][hdr[5:2]][npos(rise - dev_pre) +: 4];
    dev_oe  = 1'b1;
  end

  always @(negedge clk) begin
    if (csv != 3'b111) cur_len++;
    else if (cur_len > 0) begin last_len = cur_len; cur_len = 0; end
    if (dev_oe && sd_oe_o != 4'h0) chk(0, "R2", "pad contention", {28'h0, sd_oe_o}, 32'h0);
  end

  task automatic do_reset(input int lat, input bit half);
    @(negedge clk);
    rst_ni = 1'b0;
    cfg_nib = {1'b0, half, 2'(lat)};
    lat_cfg = lat;
    repeat (10) @(negedge clk);
    chk(csv == 3'b111 && sd_oe_o == 4'h0 && !sck_o, "R2", "pads in reset",
        {24'h0, sck_o, csv, sd_oe_o}, 32'h70);
    chk(!instr_ready_o && !data_ready_o, "R13", "ready in reset",
        {30'h0, instr_ready_o, data_ready_o}, 32'h0);
    rst_ni = 1'b1;
    cfg_nib = 4'hF;
    @(negedge clk);
  endtask

  task automatic xfer(input bit use_data, input bit we, input logic [24:0] addr,
                      input logic [31:0] wdata, output logic [31:0] rdata, output int len);
    @(negedge clk);
    if (use_data) begin
      data_req = 1; data_we = we; data_addr = addr; data_wdata = wdata;
    end else begin
      instr_req = 1; instr_addr = addr[23:0];
    end
    do @(negedge clk); while (!(use_data ? data_ready_o : instr_ready_o));
    rdata = use_data ? data_rdata_o : instr_rdata_o;
    data_req = 0; instr_req = 0;
    @(negedge clk);
    chk(!data_ready_o && !instr_ready_o, "R13", "ready is one pulse", 32'h0, 32'h0);
    len = last_len;
  endtask

  task automatic t_flash_read(input int lat, input bit half);
    logic [31:0] r; int len;
    int f0 = falls[0];
    xfer(0, 0, 25'h0000008, '0, r, len);
    chk(r == mem[0][2], "R5", "fetch word", r, mem[0][2]);
    chk(len == 2 * (14 + lat) - int'(half), "R7", "flash read length", len, 2 * (14 + lat) - int'(half));
    chk(falls[0] == f0 + 1 && last_hdr[23:0] == 24'h000008, "R1", "flash select and address",
        last_hdr, 32'h8);
    xfer(1, 0, 25'h000003C, '0, r, len);
    chk(r == mem[0][15], "R6", "data port flash word", r, mem[0][15]);
  endtask

  task automatic t_ram(input int lat, input bit half);
    logic [31:0] r; int len;
    xfer(1, 1, 25'h1000010, 32'hDEADBEEF, r, len);
    chk(len == 32, "R10", "write length", len, 32);
    chk(last_hdr[31:24] == 8'h38, "R10", "write command", last_hdr[31:24], 8'h38);
    chk(mem[1][4] == 32'hDEADBEEF, "R10", "RAM A written", mem[1][4], 32'hDEADBEEF);
    xfer(1, 1, 25'h1800010, 32'h12345678, r, len);
    chk(mem[2][4] == 32'h12345678 && last_hdr[23:0] == 24'h000010, "R1", "RAM B write/address",
        mem[2][4], 32'h12345678);
    xfer(1, 0, 25'h1000010, '0, r, len);
    chk(r == 32'hDEADBEEF, "R1", "RAM A unaffected by RAM B", r, 32'hDEADBEEF);
    chk(last_hdr[31:24] == 8'hEB, "R9", "read command", last_hdr[31:24], 8'hEB);
    chk(len == 2 * (16 + lat) - int'(half), "R9", "PSRAM read length", len, 2 * (16 + lat) - int'(half));
  endtask

  task automatic t_flash_write;
    logic [31:0] r, old; int len;
    int n = falls[0] + falls[1] + falls[2];
    old = mem[0][1];
    xfer(1, 1, 25'h0000004, 32'h0BADF00D, r, len);
    chk(falls[0] + falls[1] + falls[2] == n, "R11", "no select on flash write",
        falls[0] + falls[1] + falls[2], n);
    xfer(1, 0, 25'h0000004, '0, r, len);
    chk(r == old, "R11", "flash contents kept", r, old);
  endtask

  task automatic t_priority;
    int f0 = falls[0];
    logic [31:0] rd, ri;
    @(negedge clk);
    data_req = 1; data_we = 0; data_addr = 25'h1800010;
    instr_req = 1; instr_addr = 24'h00000C;
    do @(negedge clk); while (!data_ready_o && !instr_ready_o);
    chk(data_ready_o && !instr_ready_o, "R12", "data served first",
        {30'h0, data_ready_o, instr_ready_o}, 32'h2);
    chk(falls[0] == f0, "R12", "flash waits for release", falls[0], f0);
    rd = data_rdata_o;
    data_req = 0;
    do @(negedge clk); while (!instr_ready_o);
    ri = instr_rdata_o;
    instr_req = 0;
    @(negedge clk);
    chk(rd == mem[2][4], "R12", "data word", rd, mem[2][4]);
    chk(ri == mem[0][3], "R12", "fetch word after wait", ri, mem[0][3]);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run timed out", 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int d = 0; d < 3; d++)
      for (int i = 0; i < 16; i++)
        mem[d][i] = 32'hA5C30000 ^ (32'(d) << 12) ^ (32'(i) * 32'h01030507);
    for (int d = 0; d < 3; d++) falls[d] = 0;
    do_reset(2, 0);
    t_flash_read(2, 0);
    t_ram(2, 0);
    t_flash_write;
    t_priority;
    do_reset(1, 1);   // R3 R8
    t_flash_read(1, 1);
    t_ram(1, 1);
    do_reset(3, 0);   // R3
    t_flash_read(3, 0);
    do_reset(0, 0);   // R3
    t_flash_read(0, 0);
    t_ram(0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule